// File: doc/BRIEF.md
# Lockable System Configuration Register Bank

This block is a small APB register file that drives the static control pins of a processor cluster and its neighbours: a run/hold enable and four configuration straps per processor, a byte-strobe mask for a DMA engine's writes, the user sideband fields on a cache-coherent port, an LED bank, and a readable switch bank. It also returns a fixed identification word and a feature word that reports which optional registers exist. The APB side never stalls and never signals an error.

The processor and DMA control registers are guarded by a 16-bit key register. APB writes to those registers take effect only while the key holds the value 0xA05F. To change a guarded register, software writes 0xA05F to the key, updates the register, and then writes any other value to close the bank again. A second write port, the preload port, lets power-up logic set any configuration register without the key. The preload port cannot touch the key itself. When it is idle for a register, that register keeps its reset value.

The write byte strobes of the DMA engine pass through the block, and each strobe bit is cleared where the mask bit is set.

Top module: `cfgreg_lockbank`

## Requirements
- R1: `pready` is always 1 and `pslverr` is always 0. Every access completes in its access phase with no wait state.
- R2: The key register is at offset 0x120 and resets to 0. An APB write stores `pwdata[15:0]`. A read returns the stored value in [15:0], 1 in bit 16 while that value equals 0xA05F, and 0 in [31:17].
- R3: A preload write to offset 0x120 leaves the key register unchanged.
- R4: Processor i has a control register at offset 0x008 + 4·i. Bit 0 drives `cpu_en[i]`, where 0 holds that processor in reset. Bits [11:8] drive `cpu_cfg[4i+3:4i]`. All other bits read 0. The register resets to 0x00000001.
- R5: While the key does not hold 0xA05F, APB writes to the processor control registers and to the DMA mask register are ignored. While it does hold 0xA05F, such writes take effect.
- R6: The DMA mask register is at 0x01C. Bits [7:0] are stored and the register resets to 0. `dma_strb_out[b] = dma_strb_in[b] & ~mask[b]`.
- R7: The coherency register is at 0x020 and is not guarded by the key. Bits [21:16] drive `coh_wuser` and bits [5:0] drive `coh_ruser`. It resets to 0.
- R8: The LED register is at 0x104. Bits [7:0] drive `led_o` and reset to 0. The switch register at 0x108 reads `sw_i` in [7:0].
- R9: The feature register at 0xFF8 is read-only. It returns BUILD_NUM in [31:24] and 1 in bits 10, 9 and 8 (switch, LED and lock-status registers present). Bits [7:0] hold NCPU+2, which is 4 by default. Writes to it have no effect.
- R10: The ID register at 0xFFC is read-only. It returns 0x41 in [31:24], ID_VARIANT in [23:20], 0x5 in [19:16], 0 in [15:12], ID_PART in [11:4] and ID_REV in [3:0].
- R11: A preload write sets any processor, DMA, coherency or LED register whatever the key holds. In a cycle with a preload write, a concurrent APB write is dropped, so the preload wins on the same register.
- R12: Unmapped offsets read 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Clock |
| presetn | input | 1 | Active-low synchronous reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write when 1 |
| paddr | input | 12 | APB byte offset |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data |
| pready | output | 1 | Always 1 |
| pslverr | output | 1 | Always 0 |
| pre_wr | input | 1 | Preload write strobe |
| pre_addr | input | 12 | Preload offset |
| pre_wdata | input | 32 | Preload data |
| cpu_en | output | NCPU | Processor run enables |
| cpu_cfg | output | 4·NCPU | Processor configuration straps |
| dma_strb_in | input | 8 | DMA write byte strobes in |
| dma_strb_out | output | 8 | Masked DMA write byte strobes |
| coh_wuser | output | 6 | Coherent-port write user field |
| coh_ruser | output | 6 | Coherent-port read user field |
| led_o | output | 8 | LED drive |
| sw_i | input | 8 | Switch state |

## Verification
The hardest situation to reach is the collision between the two write paths. It arises when a preload write lands in the same cycle as an APB access phase, either to the same register or to the key while the bank is open. The stimulus raises `pre_wr` exactly in the access cycle of an APB write. Read-backs then show which value won, and that the key kept its open value through a preload aimed at it. The guarded case is exercised both ways: a write is tried while the bank is closed, the bank is opened, the same write is repeated, and the bank is then closed again.

// File: rtl/cfgreg_pkg.sv
package cfgreg_pkg;
  localparam int AW = 12;
  localparam int DW = 32;

  localparam logic [AW-1:0] OFS_CPU_BASE = 12'h008;
  localparam logic [AW-1:0] OFS_DMA      = 12'h01C;
  localparam logic [AW-1:0] OFS_COH      = 12'h020;
  localparam logic [AW-1:0] OFS_LED      = 12'h104;
  localparam logic [AW-1:0] OFS_SW       = 12'h108;
  localparam logic [AW-1:0] OFS_KEY      = 12'h120;
  localparam logic [AW-1:0] OFS_FEAT     = 12'hFF8;
  localparam logic [AW-1:0] OFS_ID       = 12'hFFC;

  localparam logic [15:0] KEY_MAGIC = 16'hA05F;
  localparam logic [7:0]  ID_MAKER  = 8'h41;
  localparam logic [3:0]  ID_ARCH   = 4'h5;

  localparam int CFG_W   = 4;   // straps per processor
  localparam int CFG_LSB = 8;   // strap field position in control word

  typedef struct packed {
    logic             en;
    logic [CFG_W-1:0] cfg;
  } cpu_ctl_t;

  function automatic logic [AW-1:0] cpu_ofs(input int idx);
    return OFS_CPU_BASE + AW'(4 * idx);
  endfunction
endpackage

// File: rtl/cfgreg_wr_arb.sv
module cfgreg_wr_arb
  import cfgreg_pkg::*;
#(
  parameter int NCPU = 2
) (
  input  logic                 apb_wr,
  input  logic [AW-1:0]        apb_addr,
  input  logic [DW-1:0]        apb_wdata,
  input  logic                 pre_wr,
  input  logic [AW-1:0]        pre_addr,
  input  logic [DW-1:0]        pre_wdata,
  input  logic                 unlocked,
  output logic [NCPU-1:0]      we_cpu,
  output logic                 we_dma,
  output logic                 we_coh,
  output logic                 we_led,
  output logic                 we_key,
  output logic [DW-1:0]        wdata
);
  logic [AW-1:0] a;
  logic          any_wr;
  logic          guard_ok;

  // preload path takes the cycle; a concurrent APB write is dropped
  assign a        = pre_wr ? pre_addr  : apb_addr;
  assign wdata    = pre_wr ? pre_wdata : apb_wdata;
  assign any_wr   = pre_wr | apb_wr;
  assign guard_ok = pre_wr | unlocked;

  for (genvar i = 0; i < NCPU; i++) begin : g_cpu_we
    assign we_cpu[i] = any_wr & guard_ok & (a == cpu_ofs(i));
  end

  assign we_dma = any_wr & guard_ok & (a == OFS_DMA);
  assign we_coh = any_wr & (a == OFS_COH);
  assign we_led = any_wr & (a == OFS_LED);
  assign we_key = apb_wr & ~pre_wr & (a == OFS_KEY);
endmodule

// File: rtl/cfgreg_key.sv
module cfgreg_key
  import cfgreg_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        we,
  input  logic [15:0] wdata,
  output logic [15:0] key_q,
  output logic        unlocked
);
  always_ff @(posedge clk) begin
    if (!rst_n)  key_q <= '0;
    else if (we) key_q <= wdata;
  end

  assign unlocked = (key_q == KEY_MAGIC);
endmodule

// File: rtl/cfgreg_cpu_ctl.sv
module cfgreg_cpu_ctl
  import cfgreg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic             en_bit,
  input  logic [CFG_W-1:0] cfg_bits,
  output cpu_ctl_t         ctl
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl.en  <= 1'b1;
      ctl.cfg <= '0;
    end else if (we) begin
      ctl.en  <= en_bit;
      ctl.cfg <= cfg_bits;
    end
  end
endmodule

// File: rtl/cfgreg_lockbank.sv
module cfgreg_lockbank
  import cfgreg_pkg::*;
#(
  parameter int          NCPU       = 2,
  parameter int          STRB_W     = 8,
  parameter int          USER_W     = 6,
  parameter int          LED_W      = 8,
  parameter int          SW_W       = 8,
  parameter logic [7:0]  BUILD_NUM  = 8'h17,
  parameter logic [3:0]  ID_VARIANT = 4'h0,
  parameter logic [7:0]  ID_PART    = 8'hA1,
  parameter logic [3:0]  ID_REV     = 4'h2
) (
  input  logic                  pclk,
  input  logic                  presetn,
  input  logic                  psel,
  input  logic                  penable,
  input  logic                  pwrite,
  input  logic [11:0]           paddr,
  input  logic [31:0]           pwdata,
  output logic [31:0]           prdata,
  output logic                  pready,
  output logic                  pslverr,
  input  logic                  pre_wr,
  input  logic [11:0]           pre_addr,
  input  logic [31:0]           pre_wdata,
  output logic [NCPU-1:0]       cpu_en,
  output logic [4*NCPU-1:0]     cpu_cfg,
  input  logic [STRB_W-1:0]     dma_strb_in,
  output logic [STRB_W-1:0]     dma_strb_out,
  output logic [USER_W-1:0]     coh_wuser,
  output logic [USER_W-1:0]     coh_ruser,
  output logic [LED_W-1:0]      led_o,
  input  logic [SW_W-1:0]       sw_i
);
  localparam int          WUSER_LSB = 16;
  localparam logic [7:0]  NUM_CFG   = 8'(NCPU + 2);
  localparam logic [31:0] FEAT_WORD = {BUILD_NUM, 13'b0, 3'b111, NUM_CFG};
  localparam logic [31:0] ID_WORD   = {ID_MAKER, ID_VARIANT, ID_ARCH, 4'b0, ID_PART, ID_REV};

  logic                 apb_wr;
  logic [NCPU-1:0]      we_cpu;
  logic                 we_dma, we_coh, we_led, we_key;
  logic [31:0]          wdata;
  logic [15:0]          key_q;
  logic                 unlocked;
  cpu_ctl_t             ctl [NCPU];
  logic [STRB_W-1:0]    dma_mask_q;
  logic [USER_W-1:0]    wuser_q, ruser_q;
  logic [LED_W-1:0]     led_q;

  assign apb_wr  = psel & penable & pwrite;
  assign pready  = 1'b1;
  assign pslverr = 1'b0;

  cfgreg_wr_arb #(.NCPU(NCPU)) u_arb (
    .apb_wr(apb_wr), .apb_addr(paddr), .apb_wdata(pwdata),
    .pre_wr(pre_wr), .pre_addr(pre_addr), .pre_wdata(pre_wdata),
    .unlocked(unlocked),
    .we_cpu(we_cpu), .we_dma(we_dma), .we_coh(we_coh),
    .we_led(we_led), .we_key(we_key), .wdata(wdata)
  );

  cfgreg_key u_key (
    .clk(pclk), .rst_n(presetn), .we(we_key), .wdata(wdata[15:0]),
    .key_q(key_q), .unlocked(unlocked)
  );

  for (genvar i = 0; i < NCPU; i++) begin : g_cpu
    cfgreg_cpu_ctl u_ctl (
      .clk(pclk), .rst_n(presetn), .we(we_cpu[i]),
      .en_bit(wdata[0]), .cfg_bits(wdata[CFG_LSB +: CFG_W]),
      .ctl(ctl[i])
    );
    assign cpu_en[i]                  = ctl[i].en;
    assign cpu_cfg[CFG_W*i +: CFG_W]  = ctl[i].cfg;
  end

  always_ff @(posedge pclk) begin
    if (!presetn) begin
      dma_mask_q <= '0;
      wuser_q    <= '0;
      ruser_q    <= '0;
      led_q      <= '0;
    end else begin
      if (we_dma) dma_mask_q <= wdata[STRB_W-1:0];
      if (we_coh) begin
        wuser_q <= wdata[WUSER_LSB +: USER_W];
        ruser_q <= wdata[USER_W-1:0];
      end
      if (we_led) led_q <= wdata[LED_W-1:0];
    end
  end

  assign dma_strb_out = dma_strb_in & ~dma_mask_q;
  assign coh_wuser    = wuser_q;
  assign coh_ruser    = ruser_q;
  assign led_o        = led_q;

  always_comb begin
    prdata = '0;
    unique case (paddr)
      OFS_DMA:  prdata[STRB_W-1:0] = dma_mask_q;
      OFS_COH: begin
        prdata[WUSER_LSB +: USER_W] = wuser_q;
        prdata[USER_W-1:0]          = ruser_q;
      end
      OFS_LED:  prdata[LED_W-1:0] = led_q;
      OFS_SW:   prdata[SW_W-1:0]  = sw_i;
      OFS_KEY:  prdata[16:0]      = {unlocked, key_q};
      OFS_FEAT: prdata            = FEAT_WORD;
      OFS_ID:   prdata            = ID_WORD;
      default: begin
        for (int i = 0; i < NCPU; i++) begin
          if (paddr == cpu_ofs(i)) begin
            prdata[0]                  = ctl[i].en;
            prdata[CFG_LSB +: CFG_W]   = ctl[i].cfg;
          end
        end
      end
    endcase
  end
endmodule

// File: rtl/cfgreg_lockbank_chk.sv
module cfgreg_lockbank_chk
  import cfgreg_pkg::*;
#(
  parameter int NCPU   = 2,
  parameter int STRB_W = 8
) (
  input logic                pclk,
  input logic                presetn,
  input logic                psel,
  input logic                penable,
  input logic                pwrite,
  input logic [11:0]         paddr,
  input logic [31:0]         prdata,
  input logic                pready,
  input logic                pslverr,
  input logic                pre_wr,
  input logic [NCPU-1:0]     cpu_en,
  input logic [4*NCPU-1:0]   cpu_cfg,
  input logic [15:0]         key_q,
  input logic [STRB_W-1:0]   dma_mask_q
);
  logic rd_acc;
  assign rd_acc = psel & penable & ~pwrite;

  assert_no_wait_R1: assert property (@(posedge pclk) disable iff (!presetn)
    pready && !pslverr);

  assert_key_status_R2: assert property (@(posedge pclk) disable iff (!presetn)
    (rd_acc && paddr == OFS_KEY) |->
      (prdata[16] == (prdata[15:0] == KEY_MAGIC)) && (prdata[31:17] == '0));

  assert_key_preload_R3: assert property (@(posedge pclk) disable iff (!presetn)
    pre_wr |=> $stable(key_q));

  assert_cpu_reset_R4: assert property (@(posedge pclk) disable iff (!presetn)
    $rose(presetn) |-> (cpu_en == '1) && (cpu_cfg == '0));

  assert_locked_hold_R5: assert property (@(posedge pclk) disable iff (!presetn)
    (key_q != KEY_MAGIC && !pre_wr) |=>
      ($stable(cpu_en) && $stable(cpu_cfg) && $stable(dma_mask_q)));

  assert_id_word_R10: assert property (@(posedge pclk) disable iff (!presetn)
    (rd_acc && paddr == OFS_ID) |-> (prdata[31:24] == ID_MAKER) && (prdata[19:16] == ID_ARCH));
endmodule

bind cfgreg_lockbank cfgreg_lockbank_chk #(.NCPU(NCPU), .STRB_W(STRB_W)) u_chk (
  .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable), .pwrite(pwrite),
  .paddr(paddr), .prdata(prdata), .pready(pready), .pslverr(pslverr),
  .pre_wr(pre_wr), .cpu_en(cpu_en), .cpu_cfg(cpu_cfg),
  .key_q(key_q), .dma_mask_q(dma_mask_q)
);

// File: tb/cfgreg_lockbank_bench.sv
`timescale 1ns/1ps
module cfgreg_lockbank_bench;
  logic        pclk = 1'b0;
  logic        presetn = 1'b0;
  logic        psel = 0, penable = 0, pwrite = 0;
  logic [11:0] paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic        pready, pslverr;
  logic        pre_wr = 0;
  logic [11:0] pre_addr = '0;
  logic [31:0] pre_wdata = '0;
  logic [1:0]  cpu_en;
  logic [7:0]  cpu_cfg;
  logic [7:0]  dma_strb_in = 8'hFF;
  logic [7:0]  dma_strb_out;
  logic [5:0]  coh_wuser, coh_ruser;
  logic [7:0]  led_o;
  logic [7:0]  sw_i = 8'h3C;

  int n_chk = 0;
  int n_fail = 0;
  logic [31:0] exp_q [$];
  string       tag_q [$];

  always #2 pclk = ~pclk;   // 250 MHz

  cfgreg_lockbank u_cfgreg_lockbank (
    .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready), .pslverr(pslverr),
    .pre_wr(pre_wr), .pre_addr(pre_addr), .pre_wdata(pre_wdata),
    .cpu_en(cpu_en), .cpu_cfg(cpu_cfg),
    .dma_strb_in(dma_strb_in), .dma_strb_out(dma_strb_out),
    .coh_wuser(coh_wuser), .coh_ruser(coh_ruser), .led_o(led_o), .sw_i(sw_i)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // monitor: compares each read access phase against the scoreboard
  always @(negedge pclk) begin
    if (presetn && psel && penable) begin
      chk("R1", {30'b0, pready, pslverr}, 32'h2);
      if (!pwrite) begin
        if (exp_q.size() == 0) chk("scoreboard", 32'h1, 32'h0);
        else chk(tag_q.pop_front(), prdata, exp_q.pop_front());
      end
    end
  end

  task automatic apb_wr(input logic [11:0] a, input logic [31:0] d);
    @(posedge pclk); #1;
    psel = 1; pwrite = 1; paddr = a; pwdata = d; penable = 0;
    @(posedge pclk); #1; penable = 1;
    @(posedge pclk); #1; psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic apb_rd(input string req, input logic [11:0] a, input logic [31:0] exp);
    exp_q.push_back(exp); tag_q.push_back(req);
    @(posedge pclk); #1;
    psel = 1; pwrite = 0; paddr = a; penable = 0;
    @(posedge pclk); #1; penable = 1;
    @(posedge pclk); #1; psel = 0; penable = 0;
  endtask

  task automatic pre_write(input logic [11:0] a, input logic [31:0] d);
    @(posedge pclk); #1; pre_wr = 1; pre_addr = a; pre_wdata = d;
    @(posedge pclk); #1; pre_wr = 0;
  endtask

  initial begin
    #(4 * 150000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (4) @(posedge pclk);
    #1 presetn = 1;
    @(negedge pclk);
    // reset state
    chk("R4 reset en", {30'b0, cpu_en}, 32'h3);
    chk("R4 reset cfg", {24'b0, cpu_cfg}, 32'h0);
    chk("R6 reset strobes", {24'b0, dma_strb_out}, 32'hFF);
    chk("R7 reset user", {20'b0, coh_wuser, coh_ruser}, 32'h0);
    chk("R8 reset led", {24'b0, led_o}, 32'h0);
    chk("R1 idle", {30'b0, pready, pslverr}, 32'h2);
    apb_rd("R2 key reset", 12'h120, 32'h0);
    apb_rd("R4 cpu0 reset", 12'h008, 32'h1);
    apb_rd("R12 unmapped read", 12'h010, 32'h0);

    // guarded writes while closed
    apb_wr(12'h008, 32'h0000_0F00);
    apb_rd("R5 locked cpu0", 12'h008, 32'h1);
    apb_wr(12'h01C, 32'hFF);
    apb_rd("R5 locked dma", 12'h01C, 32'h0);
    @(negedge pclk);
    chk("R5 locked en", {30'b0, cpu_en}, 32'h3);

    // unguarded registers
    apb_wr(12'h020, 32'hFFFF_FFFF);
    apb_rd("R7 coh read", 12'h020, 32'h003F_003F);
    @(negedge pclk);
    chk("R7 coh outs", {20'b0, coh_wuser, coh_ruser}, 32'hFFF);
    apb_wr(12'h104, 32'h0000_A5A5);
    apb_rd("R8 led read", 12'h104, 32'hA5);
    @(negedge pclk);
    chk("R8 led out", {24'b0, led_o}, 32'hA5);
    apb_rd("R8 switch", 12'h108, 32'h3C);
    apb_wr(12'h108, 32'hFF);
    apb_rd("R12 switch write ignored", 12'h108, 32'h3C);

    // identification
    apb_rd("R9 feature", 12'hFF8, 32'h1700_0704);
    apb_wr(12'hFF8, 32'h0);
    apb_rd("R9 feature after write", 12'hFF8, 32'h1700_0704);
    apb_rd("R10 id", 12'hFFC, 32'h4105_0A12);

    // open the bank
    apb_wr(12'h120, 32'h1234_A05F);
    apb_rd("R2 key open", 12'h120, 32'h0001_A05F);
    apb_wr(12'h00C, 32'hFFFF_FFFE);
    apb_rd("R5 unlocked cpu1", 12'h00C, 32'h0000_0F00);
    @(negedge pclk);
    chk("R4 cpu1 en", {30'b0, cpu_en}, 32'h1);
    chk("R4 cpu1 cfg", {24'b0, cpu_cfg}, 32'hF0);
    apb_wr(12'h01C, 32'h0F);
    @(negedge pclk);
    chk("R6 masked strobes", {24'b0, dma_strb_out}, 32'hF0);
    dma_strb_in = 8'h5A;
    @(negedge pclk);
    chk("R6 masked pattern", {24'b0, dma_strb_out}, 32'h50);

    // preload cannot touch key
    pre_write(12'h120, 32'h0);
    apb_rd("R3 key after preload", 12'h120, 32'h0001_A05F);

    // close and retry
    apb_wr(12'h120, 32'h0000_A05E);
    apb_rd("R2 key closed", 12'h120, 32'h0000_A05E);
    apb_wr(12'h00C, 32'h1);
    apb_rd("R5 relocked cpu1", 12'h00C, 32'h0000_0F00);

    // preload ignores lock
    pre_write(12'h00C, 32'h0000_0301);
    apb_rd("R11 preload cpu1", 12'h00C, 32'h0000_0301);
    @(negedge pclk);
    chk("R11 preload en", {30'b0, cpu_en}, 32'h3);
    pre_write(12'h01C, 32'hC3);
    apb_rd("R11 preload dma", 12'h01C, 32'hC3);

    // collision: preload in the APB access cycle
    @(posedge pclk); #1;
    psel = 1; pwrite = 1; paddr = 12'h020; pwdata = 32'h0001_0002; penable = 0;
    @(posedge pclk); #1; penable = 1; pre_wr = 1; pre_addr = 12'h020; pre_wdata = 32'h0005_0006;
    @(posedge pclk); #1; psel = 0; penable = 0; pwrite = 0; pre_wr = 0;
    apb_rd("R11 collision", 12'h020, 32'h0005_0006);

    // unmapped write
    apb_wr(12'h200, 32'hDEAD_BEEF);
    apb_rd("R12 unmapped after write", 12'h200, 32'h0);
    apb_rd("R12 led intact", 12'h104, 32'hA5);

    repeat (3) @(negedge pclk);
    chk("scoreboard drained", exp_q.size(), 32'h0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule